// File: doc/BRIEF.md
# Memory Access Watch Trigger Unit

This block sits beside a core's load/store path and decides, for every memory access, whether the access touches memory that software has asked to watch. Two sources of watch information are checked in parallel. The first is a small array of per-word flags. Each word has one bit that arms it against loads and one bit that arms it against stores. The second is a short table of address ranges, so that large regions can be watched without setting one flag per word. When an access matches an armed bit from either source, the unit takes a monitoring trap. It captures the program counter of the access and sends the core to a programmable handler entry address.

Software arms and disarms watching through a command port. A word-watch command sets chosen flag bits, and a word-unwatch command clears them. A range command loads one table slot. A fourth command writes the handler entry address. While a handler runs, further accesses cannot start another trap. When the handler signals that it is finished, the unit sends the core back to the saved program counter.

Top module: `watchTrigger`

## Requirements
- R1: After reset no handler is active, `redirectValid` is low, and every word flag and range entry is disarmed, so that no access traps until a command arms one.
- R2: A load (`accWrite`=0) traps when the read bit (mode bit 0) is armed for its address. A store to an address armed only for reads does not trap.
- R3: A store (`accWrite`=1) traps when the write bit (mode bit 1) is armed for its address. A load to an address armed only for writes does not trap.
- R4: Command op 0 (watch word) ORs `cmdMode` into the flags of word `cmdAddr`. Op 1 (unwatch word) clears only the bits that are set in `cmdMode` and leaves the other bit as it was. A flag change applies to accesses from the cycle after the command.
- R5: Command op 2 loads range slot `cmdSlot` with base `cmdAddr`, limit `cmdLimit` and flags `cmdMode`. An access matches a range when base ≤ address ≤ limit, both ends inclusive, and it traps if the matching range has the bit for its access type armed.
- R6: An access that traps while idle makes `redirectValid` high for exactly the following cycle, with `redirectPc` equal to the handler entry address, and `handlerActive` high from that cycle on.
- R7: `resumeIn` while a handler is active makes `redirectValid` high in the following cycle, with `redirectPc` equal to the PC of the access that trapped, and clears `handlerActive`.
- R8: While a handler is active, accesses that would trap are ignored. They produce no redirect and do not overwrite the saved PC.
- R9: `resumeIn` while no handler is active has no effect. No redirect occurs and `handlerActive` stays low.
- R10: Command op 3 sets the handler entry address to `cmdAddr`. Its reset value is the parameter `RESET_ENTRY`.
- R11: Word flags exist only for addresses below `FLAG_WORDS`. Watch commands for higher addresses are ignored, and those addresses can be watched only through the range table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A memory access is presented this cycle |
| accWrite | input | 1 | 1 = store, 0 = load |
| accAddr | input | ADDR_W | Word address of the access |
| accPc | input | ADDR_W | PC of the instruction making the access |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 2 | 0 watch word, 1 unwatch word, 2 load range, 3 set handler entry |
| cmdMode | input | 2 | Bit 0 read watch, bit 1 write watch |
| cmdSlot | input | SLOT_W | Range table slot for op 2 |
| cmdAddr | input | ADDR_W | Word address, range base, or handler entry |
| cmdLimit | input | ADDR_W | Range limit (inclusive) for op 2 |
| resumeIn | input | 1 | Handler has completed |
| redirectValid | output | 1 | One-cycle request to load `redirectPc` into the core's PC |
| redirectPc | output | ADDR_W | Target of the redirect |
| handlerActive | output | 1 | A monitoring handler is in progress |

## Verification
The hardest case to reach from the ports is an access that would trap and arrives while a handler is already running. Only the ports show that it was dropped, and the saved PC has no direct port. The stimulus takes a trap with one PC, then makes an armed store with a different PC during the handler, and then resumes. The PC returned on resume shows whether the second access overwrote the saved state. Inclusive range bounds are probed at base−1, base, limit and limit+1, at addresses above the flag array, so that only the range table can produce a hit.

// File: rtl/watchPkg.sv
package watchPkg;
  localparam int DEF_ADDR_W     = 16;
  localparam int DEF_FLAG_WORDS = 64;
  localparam int DEF_RANGE_N    = 4;

  typedef enum logic [1:0] {
    CMD_WATCH   = 2'd0,
    CMD_UNWATCH = 2'd1,
    CMD_RANGE   = 2'd2,
    CMD_ENTRY   = 2'd3
  } cmdOp_e;

  typedef struct packed {
    logic saveState;   // capture faulting PC, redirect to handler
    logic restore;     // redirect back to saved PC
  } ctrlStrobes_t;
endpackage

// File: rtl/watchDatapath.sv
module watchDatapath
  import watchPkg::*;
#(
  parameter int ADDR_W        = DEF_ADDR_W,
  parameter int FLAG_WORDS    = DEF_FLAG_WORDS,
  parameter int RANGE_N       = DEF_RANGE_N,
  parameter int SLOT_W        = (RANGE_N > 1) ? $clog2(RANGE_N) : 1,
  parameter logic [ADDR_W-1:0] RESET_ENTRY = 'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] accPc,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdMode,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] cmdLimit,
  input  ctrlStrobes_t      strobes,
  output logic              accHit,
  output logic [ADDR_W-1:0] redirectPc
);
  localparam int IDX_W = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1;
  localparam logic [ADDR_W-1:0] FLAG_LIMIT = ADDR_W'(FLAG_WORDS);

  logic [1:0]        wordFlags  [FLAG_WORDS];
  logic [ADDR_W-1:0] rangeBase  [RANGE_N];
  logic [ADDR_W-1:0] rangeLimit [RANGE_N];
  logic [1:0]        rangeFlags [RANGE_N];
  logic [ADDR_W-1:0] handlerEntry;
  logic [ADDR_W-1:0] savedPc;

  logic [IDX_W-1:0]  cmdIdx;
  logic [IDX_W-1:0]  accIdx;
  logic              cmdInWin;
  logic              accInWin;
  logic [1:0]        accNeed;
  logic              wordHit;
  logic [RANGE_N-1:0] rangeHitVec;

  assign cmdIdx   = cmdAddr[IDX_W-1:0];
  assign accIdx   = accAddr[IDX_W-1:0];
  assign cmdInWin = cmdAddr < FLAG_LIMIT;
  assign accInWin = accAddr < FLAG_LIMIT;
  assign accNeed  = accWrite ? 2'b10 : 2'b01;

  // Per-word flag storage and command decode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FLAG_WORDS; i++) wordFlags[i] <= 2'b00;
      for (int j = 0; j < RANGE_N; j++) begin
        rangeBase[j]  <= '0;
        rangeLimit[j] <= '0;
        rangeFlags[j] <= 2'b00;
      end
      handlerEntry <= RESET_ENTRY;
    end else if (cmdValid) begin
      case (cmdOp_e'(cmdOp))
        CMD_WATCH:
          if (cmdInWin) wordFlags[cmdIdx] <= wordFlags[cmdIdx] | cmdMode;
        CMD_UNWATCH:
          if (cmdInWin) wordFlags[cmdIdx] <= wordFlags[cmdIdx] & ~cmdMode;
        CMD_RANGE:
          if (int'(cmdSlot) < RANGE_N) begin
            rangeBase[cmdSlot]  <= cmdAddr;
            rangeLimit[cmdSlot] <= cmdLimit;
            rangeFlags[cmdSlot] <= cmdMode;
          end
        CMD_ENTRY:
          handlerEntry <= cmdAddr;
        default: ;
      endcase
    end
  end

  // Range comparators, one per table slot
  for (genvar g = 0; g < RANGE_N; g++) begin : gRange
    assign rangeHitVec[g] = (|(rangeFlags[g] & accNeed)) &&
                            (accAddr >= rangeBase[g]) &&
                            (accAddr <= rangeLimit[g]);
  end

  assign wordHit = accInWin && (|(wordFlags[accIdx] & accNeed));
  assign accHit  = wordHit || (|rangeHitVec);

  // Saved state and redirect target
  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPc    <= '0;
      redirectPc <= '0;
    end else if (strobes.saveState) begin
      savedPc    <= accPc;
      redirectPc <= handlerEntry;
    end else if (strobes.restore) begin
      redirectPc <= savedPc;
    end
  end
endmodule

// File: rtl/watchControl.sv
module watchControl
  import watchPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         accValid,
  input  logic         accHit,
  input  logic         resumeIn,
  output ctrlStrobes_t strobes,
  output logic         redirectValid,
  output logic         handlerActive
);
  typedef enum logic {ST_RUN, ST_HANDLER} state_e;
  state_e state;

  always_comb begin
    strobes.saveState = (state == ST_RUN) && accValid && accHit;
    strobes.restore   = (state == ST_HANDLER) && resumeIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_RUN;
      redirectValid <= 1'b0;
    end else begin
      redirectValid <= strobes.saveState || strobes.restore;
      if (strobes.saveState)    state <= ST_HANDLER;
      else if (strobes.restore) state <= ST_RUN;
    end
  end

  assign handlerActive = (state == ST_HANDLER);
endmodule

// File: rtl/watchTrigger.sv
module watchTrigger
  import watchPkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int FLAG_WORDS = DEF_FLAG_WORDS,
  parameter int RANGE_N    = DEF_RANGE_N,
  parameter logic [ADDR_W-1:0] RESET_ENTRY = 'h0100,
  localparam int SLOT_W    = (RANGE_N > 1) ? $clog2(RANGE_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] accPc,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdMode,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] cmdLimit,
  input  logic              resumeIn,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              handlerActive
);
  ctrlStrobes_t strobes;
  logic         accHit;

  watchDatapath #(
    .ADDR_W(ADDR_W), .FLAG_WORDS(FLAG_WORDS), .RANGE_N(RANGE_N),
    .SLOT_W(SLOT_W), .RESET_ENTRY(RESET_ENTRY)
  ) uDatapath (
    .clk(clk), .rstN(rstN),
    .accWrite(accWrite), .accAddr(accAddr), .accPc(accPc),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMode(cmdMode),
    .cmdSlot(cmdSlot), .cmdAddr(cmdAddr), .cmdLimit(cmdLimit),
    .strobes(strobes), .accHit(accHit), .redirectPc(redirectPc)
  );

  watchControl uControl (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accHit(accHit), .resumeIn(resumeIn),
    .strobes(strobes), .redirectValid(redirectValid),
    .handlerActive(handlerActive)
  );
endmodule

// File: rtl/watchTriggerChecker.sv
module watchTriggerChecker
  import watchPkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         accValid,
  input logic         resumeIn,
  input logic         redirectValid,
  input logic         handlerActive,
  input ctrlStrobes_t strobes
);
  AST_TRAP_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.saveState |=> (handlerActive && redirectValid)); // R6

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (handlerActive && !resumeIn) |=> (handlerActive && !redirectValid)); // R8

  AST_RESUME_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    (handlerActive && resumeIn) |=> (redirectValid && !handlerActive)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!handlerActive && !accValid) |=> (!redirectValid && !handlerActive)); // R9

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.saveState && strobes.restore)); // R8
endmodule

bind watchTrigger watchTriggerChecker uChecker (
  .clk(clk), .rstN(rstN), .accValid(accValid), .resumeIn(resumeIn),
  .redirectValid(redirectValid), .handlerActive(handlerActive),
  .strobes(strobes)
);

// File: tb/tb_watchTrigger.sv
module tb_watchTrigger;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] ENTRY_A = 16'h0400;
  localparam logic [AW-1:0] ENTRY_B = 16'h0500;

  // {write, addr, expectTrap}
  localparam int NVEC = 15;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 16'd5,     1'b1},  // R2 load on read-armed word
    {1'b1, 16'd5,     1'b0},  // R2 store on read-only word
    {1'b1, 16'd6,     1'b1},  // R3 store on write-armed word
    {1'b0, 16'd6,     1'b0},  // R3 load on write-only word
    {1'b0, 16'd7,     1'b0},  // R4 read bit cleared by unwatch
    {1'b1, 16'd7,     1'b1},  // R4 write bit kept
    {1'b1, 16'd99,    1'b0},  // R5 below base
    {1'b1, 16'd100,   1'b1},  // R5 base inclusive
    {1'b1, 16'd120,   1'b1},  // R5 limit inclusive
    {1'b1, 16'd121,   1'b0},  // R5 above limit
    {1'b0, 16'd110,   1'b0},  // R5 load in write-only range
    {1'b0, 16'h0200,  1'b1},  // R5 single-word range
    {1'b0, 16'h0201,  1'b0},  // R5 just past it
    {1'b0, 16'd8,     1'b0},  // R1 never armed word
    {1'b0, 16'd70,    1'b0}   // R11 watch above flag array ignored
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [AW-1:0] accAddr = '0, accPc = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0, cmdMode = '0;
  logic [1:0] cmdSlot = '0;
  logic [AW-1:0] cmdAddr = '0, cmdLimit = '0;
  logic resumeIn = 1'b0;
  logic redirectValid, handlerActive;
  logic [AW-1:0] redirectPc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  watchTrigger dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accPc(accPc), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdMode(cmdMode), .cmdSlot(cmdSlot), .cmdAddr(cmdAddr),
    .cmdLimit(cmdLimit), .resumeIn(resumeIn), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .handlerActive(handlerActive)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [1:0] slot, input logic [1:0] mode,
                         input logic [AW-1:0] a, input logic [AW-1:0] lim);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdSlot = slot; cmdMode = mode;
    cmdAddr = a; cmdLimit = lim;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [AW-1:0] pc);
    @(negedge clk);
    accValid = 1'b1; accWrite = w; accAddr = a; accPc = pc;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic resume();
    @(negedge clk);
    resumeIn = 1'b1;
    @(negedge clk);
    resumeIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 redirectValid", 32'(redirectValid), 0);
    check("R1 handlerActive", 32'(handlerActive), 0);
    access(1'b0, 16'd5, 16'h0010);
    check("R1 no trap before arming", 32'(redirectValid), 0);

    sendCmd(2'd3, 2'd0, 2'b00, ENTRY_A, 16'd0);
    sendCmd(2'd0, 2'd0, 2'b01, 16'd5, 16'd0);
    sendCmd(2'd0, 2'd0, 2'b10, 16'd6, 16'd0);
    sendCmd(2'd0, 2'd0, 2'b11, 16'd7, 16'd0);
    sendCmd(2'd1, 2'd0, 2'b01, 16'd7, 16'd0);
    sendCmd(2'd2, 2'd0, 2'b10, 16'd100, 16'd120);
    sendCmd(2'd2, 2'd1, 2'b01, 16'h0200, 16'h0200);
    sendCmd(2'd0, 2'd0, 2'b11, 16'd70, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [AW-1:0] pc;
      pc = 16'h1000 + AW'(i);
      access(VEC[i][17], VEC[i][16:1], pc);
      check($sformatf("R2/R3/R5 vec %0d trap", i), 32'(redirectValid), 32'(VEC[i][0]));
      if (VEC[i][0]) begin
        check("R6 redirect to entry", 32'(redirectPc), 32'(ENTRY_A));
        check("R6 handler active", 32'(handlerActive), 1);
        @(negedge clk);
        check("R6 single-cycle redirect", 32'(redirectValid), 0);
        resume();
        check("R7 resume redirect", 32'(redirectValid), 1);
        check("R7 resume pc", 32'(redirectPc), 32'(pc));
        check("R7 handler cleared", 32'(handlerActive), 0);
      end
    end

    // R8: nested access while handler runs
    access(1'b0, 16'd5, 16'h1111);
    check("R8 first trap", 32'(redirectValid), 1);
    access(1'b1, 16'd6, 16'h2222);
    check("R8 nested ignored", 32'(redirectValid), 0);
    check("R8 still active", 32'(handlerActive), 1);
    resume();
    check("R8 saved pc kept", 32'(redirectPc), 32'h1111);

    // R9: resume while idle
    resume();
    check("R9 idle resume no redirect", 32'(redirectValid), 0);
    check("R9 idle resume inactive", 32'(handlerActive), 0);

    // R10: change handler entry
    sendCmd(2'd3, 2'd0, 2'b00, ENTRY_B, 16'd0);
    access(1'b1, 16'd6, 16'h3333);
    check("R10 new entry", 32'(redirectPc), 32'(ENTRY_B));
    resume();
    check("R10 resume pc", 32'(redirectPc), 32'h3333);

    // R4: unwatch clears remaining bit; re-arm takes effect
    sendCmd(2'd1, 2'd0, 2'b10, 16'd7, 16'd0);
    access(1'b1, 16'd7, 16'h4444);
    check("R4 fully unwatched", 32'(redirectValid), 0);
    sendCmd(2'd0, 2'd0, 2'b01, 16'd7, 16'd0);
    access(1'b0, 16'd7, 16'h4445);
    check("R4 rewatched read", 32'(redirectValid), 1);
    resume();

    // R1: reset disarms everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    access(1'b0, 16'd5, 16'h5555);
    check("R1 flags cleared by reset", 32'(redirectValid), 0);
    access(1'b1, 16'd100, 16'h5556);
    check("R1 ranges cleared by reset", 32'(redirectValid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule